// File: doc/BRIEF.md
# Framed Serial Register-Write Decoder

This block takes the byte stream coming out of a UART receiver and turns control frames into register writes. A frame opens with a fixed five-byte sync pattern: 0x40, 0x4C, 0x44, 0x53, 0x7E. Any number of 16-bit command words follow. A single 0x7E byte closes the frame. Each command word packs a 4-bit register address and an 8-bit data value into scattered bit positions. Two of its bits are inverted copies of data bits, and the block uses them as a check.

For every complete word the block unpacks the fields. A word that passes the check produces a one-cycle write strobe with its address and data. A word that fails produces a one-cycle error pulse and no write. Bytes presented while `rx_valid` is low are not seen at all. Strobes appear in arrival order, one clock after the second byte of the word.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset `wr_stb` and `chk_err` are low and the block is looking for the sync pattern.
- R2: Command bytes are decoded only after the full five-byte sync sequence 0x40, 0x4C, 0x44, 0x53, 0x7E has been received in that order. Before that, no strobe and no error is produced.
- R3: A word arrives high byte first. Its register address is word bits 11:8. Its data is {word[13:12], word[5:0]}. The strobe, with address and data, appears one clock after the low byte is accepted.
- R4: A word passes the check only if word bit 6 equals the inverse of word bit 5 and word bit 14 equals the inverse of word bit 13. A word that fails gives a one-cycle `chk_err` pulse and no strobe.
- R5: Word bits 7 and 15 do not affect the strobe, the error, the address or the data.
- R6: A 0x7E received where a new word would begin ends the frame, and later words are ignored until the next sync sequence. A 0x7E received as the low byte of a word is treated as word data.
- R7: Any byte that does not match the expected sync byte restarts the search. That same byte is checked again as a possible first sync byte.
- R8: A frame may carry any number of words (at least eighteen). Each word produces exactly one strobe or one error, in arrival order.
- R9: A cycle with `rx_valid` low changes no state and produces no strobe or error.
- R10: `wr_stb` and `chk_err` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address of the write |
| wr_data | output | 8 | Data of the write |
| chk_err | output | 1 | One-cycle pulse for a word that fails the check |

## Verification
The hardest case to reach from the ports is a 0x7E byte in the low-byte position of a word. It must be taken as data, not as the end of the frame. Such a byte always fails the check, so the bench sends it inside a frame and expects an error pulse. A following valid word must then still produce a strobe. The restart rule is reached with a doubled 0x40 at the start of a frame. Word order is exercised by a table of twenty words, sent back to back in one frame, that mixes corrupt check bits with set don't-care bits.

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       wr_stb,
  output logic [3:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       chk_err
);
  localparam logic [7:0] SYNC0 = 8'h40;
  localparam logic [7:0] ENDB  = 8'h7E;

  typedef enum logic [1:0] {S_HUNT, S_HI, S_LO} st_t;

  st_t        st;
  logic [2:0] pidx;
  logic [7:0] hi_q;

  function automatic logic [7:0] sync_byte(input logic [2:0] i);
    case (i)
      3'd0:    sync_byte = SYNC0;
      3'd1:    sync_byte = 8'h4C;
      3'd2:    sync_byte = 8'h44;
      3'd3:    sync_byte = 8'h53;
      default: sync_byte = ENDB;
    endcase
  endfunction

  wire [15:0] word    = {hi_q, rx_byte};
  wire        word_ok = (word[6] == ~word[5]) && (word[14] == ~word[13]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_HUNT;
      pidx    <= '0;
      hi_q    <= '0;
      wr_stb  <= 1'b0;
      chk_err <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb  <= 1'b0;
      chk_err <= 1'b0;
      if (rx_valid) begin
        case (st)
          S_HUNT: begin
            if (rx_byte == sync_byte(pidx)) begin
              if (pidx == 3'd4) begin
                st   <= S_HI;
                pidx <= '0;
              end else begin
                pidx <= pidx + 3'd1;
              end
            end else begin
              pidx <= (rx_byte == SYNC0) ? 3'd1 : 3'd0;
            end
          end
          S_HI: begin
            if (rx_byte == ENDB) begin
              st <= S_HUNT;
            end else begin
              hi_q <= rx_byte;
              st   <= S_LO;
            end
          end
          S_LO: begin
            st <= S_HI;
            if (word_ok) begin
              wr_stb  <= 1'b1;
              wr_addr <= word[11:8];
              wr_data <= {word[13:12], word[5:0]};
            end else begin
              chk_err <= 1'b1;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_frame_decoder_chk.sv
module cmd_frame_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       wr_stb,
  input logic       chk_err
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && chk_err));

  p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |=> !chk_err);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!wr_stb && !chk_err));

  p_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!wr_stb && !chk_err));
endmodule

bind cmd_frame_decoder cmd_frame_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
  .wr_stb(wr_stb), .chk_err(chk_err)
);

// File: tb/cmd_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module cmd_frame_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       wr_stb, chk_err;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_fail = 0;
  logic       s_stb, s_err;
  logic [3:0] s_addr;
  logic [7:0] s_data;

  always #2.5 clk = ~clk;

  cmd_frame_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .chk_err(chk_err)
  );

  // {corrupt_b14, corrupt_b6, set_b15, set_b7, addr[3:0], data[7:0]}
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h01FF, 16'h02A5, 16'h035A, 16'h0480,
    16'h0540, 16'h0620, 16'h07DF, 16'h1811, 16'h2922,
    16'h3A7E, 16'h4B33, 16'h8C44, 16'hCD55, 16'h0E3F,
    16'h0FC0, 16'h0101, 16'h0210, 16'h7F99, 16'h0C7E
  };

  function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
    enc = {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'hA5;
    s_stb = wr_stb; s_err = chk_err; s_addr = wr_addr; s_data = wr_data;
  endtask

  task automatic sync();
    send(8'h40); send(8'h4C); send(8'h44); send(8'h53); send(8'h7E);
  endtask

  task automatic expect_write(input logic [3:0] a, input logic [7:0] d, input string req);
    check(s_stb === 1'b1 && s_err === 1'b0, req, "strobe", {s_stb, s_err}, 2);
    check(s_addr === a && s_data === d, req, "addr/data", {s_addr, s_data}, {a, d});
  endtask

  task automatic expect_quiet(input string req);
    check(s_stb === 1'b0 && s_err === 1'b0, req, "quiet", {s_stb, s_err}, 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    check(wr_stb === 1'b0 && chk_err === 1'b0, "R1", "reset outputs", {wr_stb, chk_err}, 0);
    rst_n = 1'b1;

    // R1/R2: word bytes before any sync give nothing
    w = enc(4'h3, 8'h12);
    send(w[15:8]); send(w[7:0]);
    expect_quiet("R1");

    // R2: partial sync then a mismatch, then a word: no write
    send(8'h40); send(8'h4C); send(8'h44); send(8'h00);
    w = enc(4'h5, 8'h66);
    send(w[15:8]); send(w[7:0]);
    expect_quiet("R2");

    // R3 R4 R5 R8: table of words in one frame, in order
    sync();
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v = VEC[i];
      logic [15:0] x = enc(v[11:8], v[7:0]);
      if (v[12]) x[7] = 1'b1;
      if (v[13]) x[15] = 1'b1;
      if (v[14]) x[6] = ~x[6];
      if (v[15]) x[14] = ~x[14];
      send(x[15:8]);
      expect_quiet("R8");
      send(x[7:0]);
      if (v[15:14] != 2'b00)
        check(s_err === 1'b1 && s_stb === 1'b0, "R4", "check error", {s_stb, s_err}, 1);
      else if (v[13:12] != 2'b00)
        expect_write(v[11:8], v[7:0], "R5");
      else
        expect_write(v[11:8], v[7:0], "R3");
    end
    // R6: 0x7E as low byte is data (fails check), frame continues
    send(8'h12); send(8'h7E);
    check(s_err === 1'b1 && s_stb === 1'b0, "R6", "low-byte 7E as data", {s_stb, s_err}, 1);
    w = enc(4'h9, 8'hC3);
    send(w[15:8]); send(w[7:0]);
    expect_write(4'h9, 8'hC3, "R6");
    // R6: terminator ends the frame, later words ignored
    send(8'h7E);
    w = enc(4'h1, 8'h01);
    send(w[15:8]); send(w[7:0]);
    expect_quiet("R6");

    // R7: doubled first sync byte still locks
    send(8'h40); send(8'h40); send(8'h4C); send(8'h44); send(8'h53); send(8'h7E);
    w = enc(4'hA, 8'h5B);
    send(w[15:8]); send(w[7:0]);
    expect_write(4'hA, 8'h5B, "R7");

    // R9: bytes on rx_byte with rx_valid low are not taken
    @(negedge clk); rx_byte = 8'h7E;
    @(negedge clk); rx_byte = 8'h00;
    w = enc(4'h6, 8'h81);
    send(w[15:8]); send(w[7:0]);
    expect_write(4'h6, 8'h81, "R9");

    // R10: strobe lasts one cycle
    @(negedge clk);
    check(wr_stb === 1'b0, "R10", "strobe width", wr_stb, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule